// File: doc/BRIEF.md
# Supply Supervisor with Hysteresis Reset

This block turns two digital comparator flags on the core supply into the chip's internal reset. One flag says the supply is above a startup level. The other says the supply is below a lower shutdown level. Both flags pass through two-flop synchronizers before any logic uses them. The internal reset is released only after the startup flag has held for a qualification time of `TPOR_CYC` clock cycles. The reset is asserted again as soon as the synchronized shutdown flag is seen.

The two levels are separate. When neither flag is set, the supply lies between them and the block keeps its present state. As a result, a supply that slowly sags toward the shutdown level never toggles the reset. A supply hovering just above that level does not cause repeated resets either. After every shutdown, the full qualification time must pass again before the next release.

The block has three outputs. The internal reset is active low. A shutdown indication is high while the supply is considered dead. A one-cycle pulse marks each release from reset.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst_n` is low at a rising edge, after that edge `core_rst_n_o` is 0, `shutdown_o` is 1, `por_pulse_o` is 0, and the qualification timer is cleared. After `rst_n` returns high with the startup flag set and the shutdown flag clear, release follows `TPOR_CYC+2` edges later.
- R2: With `sup_low_i` at 0, suppose `sup_ok_i` rises and then stays high. `core_rst_n_o` goes to 1 after exactly the `TPOR_CYC+2`-th rising edge following the change: two edges of synchronization plus `TPOR_CYC` counting edges. It is still 0 after the edge before that one.
- R3: `por_pulse_o` is 1 for exactly one cycle, the first cycle in which `core_rst_n_o` is 1, and is 0 at all other times.
- R4: When `sup_low_i` rises, after the third rising edge `core_rst_n_o` is 0 and `shutdown_o` is 1. This holds from the running state and from the qualifying state. After the second edge the outputs are still unchanged.
- R5: With both flags at 0, the state is held. A running block stays released with no pulse. A block in shutdown stays in shutdown.
- R6: If `sup_ok_i` falls during qualification while `sup_low_i` stays 0, the timer restarts from zero. Release then comes `TPOR_CYC+2` edges after `sup_ok_i` rises again. `shutdown_o` stays 0 during the dip.
- R7: `shutdown_o` drops to 0 after the third rising edge following a rise of `sup_ok_i` while `sup_low_i` is 0. This is the start of qualification.
- R8: After a shutdown, a new release needs the full `TPOR_CYC` qualification again. Counting done before the shutdown is not kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Master reset, active low, sampled on the rising edge |
| sup_ok_i | input | 1 | Comparator flag: supply above the startup level (asynchronous) |
| sup_low_i | input | 1 | Comparator flag: supply below the shutdown level (asynchronous) |
| core_rst_n_o | output | 1 | Internal reset to the core, active low |
| shutdown_o | output | 1 | High while the supply is treated as dead |
| por_pulse_o | output | 1 | One-cycle pulse when reset is released |

## Verification
The assertions assume that the two comparator flags are never high together. A supply cannot be above the startup level and below the shutdown level at the same moment. They also assume that every flag change lasts long enough to cross the synchronizer. The stimulus sets both flags together on the falling clock edge and always pairs a raised shutdown flag with a cleared startup flag. Each level is held for at least several cycles. The dip and mid-qualification shutdown cases check the restart-from-zero behaviour against exact edge counts.

// File: rtl/sup_pkg.sv
// Package: shared types for the supply supervisor.
// Assumes: nothing beyond the 1800-2017 language.
package sup_pkg;
    // Supervisor states: supply dead, counting qualification, released.
    typedef enum logic [1:0] {
        SUP_OFF  = 2'd0,
        SUP_QUAL = 2'd1,
        SUP_RUN  = 2'd2
    } sup_state_e;
endpackage

// File: rtl/sup_sync.sv
// Module: multi-stage flop synchronizer for a small bundle of level flags.
// Assumes: each input level is held for more than STAGES clock cycles;
// reset loads RST_VAL into every stage.
module sup_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Capture the asynchronous input into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d_i;
            end
        end else begin : g_next
            // Pass the value one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sup_qual_timer.sv
// Module: qualification timer. It counts consecutive enabled cycles and
// flags the cycle that completes TPOR_CYC of them.
// Assumes: TPOR_CYC >= 1; en_i drops or clr_i rises to restart from zero.
module sup_qual_timer #(
    parameter int TPOR_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic done_o
);
    localparam int               CNT_W = (TPOR_CYC > 1) ? $clog2(TPOR_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TPOR_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done_o = en_i && !clr_i && (cnt_q == LAST);

    // Count enabled cycles; any gap or clear restarts at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clr_i || !en_i)  cnt_q <= '0;
        else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R6
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> cnt_q == '0);
endmodule

// File: rtl/sup_ctrl.sv
// Module: supervisor state machine. It releases reset once qualification
// completes and drops it at once on a synchronized shutdown flag.
// Assumes: ok_i and low_i are synchronized and never both high.
module sup_ctrl
    import sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ok_i,
    input  logic low_i,
    input  logic qual_done_i,
    output logic qual_en_o,
    output logic qual_clr_o,
    output logic run_o,
    output logic shutdown_o,
    output logic por_o
);
    sup_state_e state_q, state_d;
    logic       por_q;

    assign qual_en_o  = (state_q != SUP_RUN) && ok_i && !low_i;
    assign qual_clr_o = (state_q == SUP_RUN) || low_i;

    // Next-state choice; the shutdown flag takes priority everywhere.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUP_OFF: begin
                if (low_i)            state_d = SUP_OFF;
                else if (qual_done_i) state_d = SUP_RUN;
                else if (ok_i)        state_d = SUP_QUAL;
            end
            SUP_QUAL: begin
                if (low_i)            state_d = SUP_OFF;
                else if (qual_done_i) state_d = SUP_RUN;
            end
            SUP_RUN: begin
                if (low_i)            state_d = SUP_OFF;
            end
            default:                  state_d = SUP_OFF;
        endcase
    end

    // State register; master reset forces the shutdown state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SUP_OFF;
        else        state_q <= state_d;
    end

    // Release pulse, raised together with the first running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) por_q <= 1'b0;
        else        por_q <= (state_q != SUP_RUN) && (state_d == SUP_RUN);
    end

    assign run_o      = (state_q == SUP_RUN);
    assign shutdown_o = (state_q == SUP_OFF);
    assign por_o      = por_q;

    // R3
    por_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_q |=> !por_q);
    // R3
    por_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_RUN && $past(state_q) != SUP_RUN) |-> por_q);
    // R2
    release_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SUP_RUN && !qual_done_i) |=> state_q != SUP_RUN);
    // R4
    low_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_i |=> state_q == SUP_OFF);
    // R5
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_RUN && !low_i) |=> state_q == SUP_RUN);
    // R6
    dip_stays_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_QUAL && !low_i) |=> state_q != SUP_OFF);
endmodule

// File: rtl/supply_supervisor.sv
// Module: supply supervisor top. It synchronizes the two comparator
// flags, times the qualification window and drives the internal reset.
// Assumes: flags come from asynchronous comparators with hysteresis
// (startup level above shutdown level); TPOR_CYC is in clock cycles.
module supply_supervisor #(
    parameter int TPOR_CYC    = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok_i,
    input  logic sup_low_i,
    output logic core_rst_n_o,
    output logic shutdown_o,
    output logic por_pulse_o
);
    // Bit 1 is the shutdown flag; it resets to "supply low".
    localparam logic [1:0] SYNC_RST = 2'b10;

    logic [1:0] flags_s;
    logic       qual_en, qual_clr, qual_done, run;

    sup_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({sup_low_i, sup_ok_i}),
        .q_o  (flags_s)
    );

    sup_qual_timer #(
        .TPOR_CYC(TPOR_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (qual_clr),
        .en_i  (qual_en),
        .done_o(qual_done)
    );

    sup_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ok_i       (flags_s[0]),
        .low_i      (flags_s[1]),
        .qual_done_i(qual_done),
        .qual_en_o  (qual_en),
        .qual_clr_o (qual_clr),
        .run_o      (run),
        .shutdown_o (shutdown_o),
        .por_o      (por_pulse_o)
    );

    assign core_rst_n_o = run;

    // R4
    low_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_s[1] |=> !core_rst_n_o && shutdown_o);
    // R7
    run_not_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rst_n_o && shutdown_o));
endmodule

// File: tb/supply_supervisor_tb.sv
module supply_supervisor_tb;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ok = 1'b0;
    logic low = 1'b1;
    logic core_rst_n, shut, por;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    supply_supervisor #(.TPOR_CYC(T)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sup_ok_i    (ok),
        .sup_low_i   (low),
        .core_rst_n_o(core_rst_n),
        .shutdown_o  (shut),
        .por_pulse_o (por)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic b);
        @(negedge clk);
        ok  = a;
        low = b;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state;
        tick(1);
        chk("R1 reset core_rst_n", core_rst_n, 1'b0);
        chk("R1 reset shutdown", shut, 1'b1);
        chk("R1 reset por", por, 1'b0);
    endtask

    task automatic t_powerup;
        drive(1'b1, 1'b0);
        tick(2);
        chk("R7 shutdown before qual", shut, 1'b1);
        tick(1);
        chk("R7 shutdown after qual start", shut, 1'b0);
        tick(T - 2);
        chk("R2 still in reset at T+1", core_rst_n, 1'b0);
        chk("R3 no pulse before release", por, 1'b0);
        tick(1);
        chk("R2 released at T+2", core_rst_n, 1'b1);
        chk("R3 pulse on release", por, 1'b1);
        tick(1);
        chk("R3 pulse one cycle", por, 1'b0);
        chk("R2 stays released", core_rst_n, 1'b1);
    endtask

    task automatic t_hover;
        drive(1'b0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (core_rst_n !== 1'b1 || por !== 1'b0)
                chk("R5 hold between levels", 1'b0, 1'b1);
        end
        chk("R5 still running", core_rst_n, 1'b1);
        chk("R5 no shutdown", shut, 1'b0);
    endtask

    task automatic t_shutdown;
        drive(1'b0, 1'b1);
        tick(2);
        chk("R4 unchanged after 2 edges", core_rst_n, 1'b1);
        tick(1);
        chk("R4 reset asserted", core_rst_n, 1'b0);
        chk("R4 shutdown high", shut, 1'b1);
        drive(1'b0, 1'b0);
        tick(30);
        chk("R5 off held between levels", shut, 1'b1);
        chk("R5 off no release", core_rst_n, 1'b0);
    endtask

    task automatic t_dip;
        drive(1'b1, 1'b0);
        tick(T / 2);
        drive(1'b0, 1'b0);
        tick(5);
        chk("R6 shutdown low during dip", shut, 1'b0);
        chk("R6 no release during dip", core_rst_n, 1'b0);
        drive(1'b1, 1'b0);
        tick(T + 1);
        chk("R6 restart: reset at T+1", core_rst_n, 1'b0);
        tick(1);
        chk("R6 restart: release at T+2", core_rst_n, 1'b1);
        chk("R3 pulse after dip", por, 1'b1);
    endtask

    task automatic t_shut_in_qual;
        drive(1'b0, 1'b1);
        tick(4);
        drive(1'b1, 1'b0);
        tick(T / 2 + 2);
        drive(1'b0, 1'b1);
        tick(2);
        chk("R4 qual unchanged after 2 edges", shut, 1'b0);
        tick(1);
        chk("R4 shutdown from qual", shut, 1'b1);
        chk("R4 reset held from qual", core_rst_n, 1'b0);
        drive(1'b1, 1'b0);
        tick(T + 1);
        chk("R8 full time again: T+1", core_rst_n, 1'b0);
        tick(1);
        chk("R8 full time again: T+2", core_rst_n, 1'b1);
    endtask

    task automatic t_master_reset;
        @(negedge clk);
        rst_n = 1'b0;
        tick(1);
        chk("R1 master reset core", core_rst_n, 1'b0);
        chk("R1 master reset shutdown", shut, 1'b1);
        chk("R1 master reset por", por, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(T + 1);
        chk("R1 after reset: T+1", core_rst_n, 1'b0);
        tick(1);
        chk("R1 after reset: T+2", core_rst_n, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        tick(3);
        t_powerup();
        t_hover();
        t_shutdown();
        t_dip();
        t_shut_in_qual();
        t_master_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule